// File: doc/BRIEF.md
# Multichannel Circular Input-Buffer Addresser

This block turns channel numbers and history offsets into addresses for one shared sample RAM that is split into one ring buffer per channel. Ten channels are served by default: indices 0 to 7 carry microphone streams and indices 8 and 9 carry reference streams. All channels use the same buffer length. The buffer of channel n begins at a common start address plus n times a programmed pitch, and every address sum wraps modulo 2^11.

A producer presents a channel index with a write request and receives, in the same cycle, the RAM address where the new sample belongs. The channel's write pointer then advances. A filter engine presents a channel index and an offset k, where k = 0 names the newest sample, and receives the address of that sample in the same cycle. If the channel has not yet produced k+1 samples, the read is out of bounds. That raises a sticky error flag, which has its own interrupt enable and is cleared by a one-cycle clear pulse. Disabling a channel empties its ring.

Top module: `chan_ring_addresser`

## Requirements
- R1: The base of channel n is (cfg_start + n*cfg_pitch) mod 2^11. While wr_req is high, wr_addr shows, in the same cycle, that base plus the channel's current write pointer.
- R2: Each accepted write advances the channel's write pointer by one. After a write at slot cfg_size_m1, the pointer returns to 0.
- R3: A read at offset k < fill gives rd_addr = base + ((wptr - 1 - k) mod (cfg_size_m1+1)) in the same cycle, taken from the state before any write in that same cycle.
- R4: The fill count of a channel rises by one per accepted write and stops at cfg_size_m1+1. Once a buffer has wrapped, every offset from 0 to cfg_size_m1 is valid.
- R5: A read with rd_req high and rd_ofs >= fill is out of bounds, as is a read of a disabled channel or of an index of 10 or above. Such a read returns the channel base on rd_addr and sets err_flag from the next cycle.
- R6: err_flag stays high until a cycle with err_clr high. If an out-of-bounds read and err_clr fall in the same cycle, the flag stays set.
- R7: irq is high exactly when err_flag is high and err_ie is high.
- R8: A write to a channel whose ch_enable bit is 0, or to an index of 10 or above, changes no state. This shows as zero fill once the channel is enabled.
- R9: One cycle with a channel's ch_enable bit at 0 resets its write pointer and its fill count to 0.
- R10: Base and address sums wrap modulo 2^11. For example, start 2000 with pitch 100 places channel 9 at 852.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 11 | Start address of channel 0 |
| cfg_pitch | input | 11 | Address step between adjacent channel buffers |
| cfg_size_m1 | input | 8 | Ring length minus one, shared by all channels |
| ch_enable | input | 10 | Per-channel enable; 0 holds the channel empty |
| wr_req | input | 1 | Producer write request |
| wr_ch | input | 4 | Producer channel index |
| wr_addr | output | 11 | RAM address for the current write |
| rd_req | input | 1 | Filter read request |
| rd_ch | input | 4 | Filter channel index |
| rd_ofs | input | 8 | History offset, 0 = newest sample |
| rd_addr | output | 11 | RAM address of the requested sample |
| err_clr | input | 1 | Clear pulse for the error flag |
| err_ie | input | 1 | Interrupt enable for the error flag |
| err_flag | output | 1 | Sticky out-of-bounds flag |
| irq | output | 1 | Masked error interrupt |

## Verification
Writes are first spread over all ten channels with small start and pitch values, so that a wrong channel multiplier or a swapped index gives an address off by a whole pitch. One channel is then written beyond its ring length and read at every offset. This separates a correct modular wrap from an off-by-one in the pointer or the fill cap. Partly filled and freshly disabled channels are read at the edge offset, where k equals fill, which tells a missing bounds check apart from a correct one. A start near the top of the address space with a large pitch shows whether the sums wrap at 11 bits.

// File: rtl/ringaddr_pkg.sv
package ringaddr_pkg;
    // default geometry of the shared sample RAM
    localparam int RA_NUM_CH = 10;
    localparam int RA_ADDR_W = 11;
    localparam int RA_LEN_W  = 8;
endpackage

// File: rtl/ring_slot.sv
// Per-channel ring state: write pointer and saturating fill count.
module ring_slot #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wr_hit,
    input  logic [LEN_W-1:0] size_m1,
    output logic [LEN_W-1:0] wptr,
    output logic [LEN_W:0]   fill
);
    localparam int FILL_W = LEN_W + 1;

    typedef struct packed {
        logic [LEN_W-1:0]  wptr;
        logic [FILL_W-1:0] fill;
    } slot_t;

    slot_t s_d, s_q;
    logic [FILL_W-1:0] size_full;

    assign size_full = {1'b0, size_m1} + FILL_W'(1);

    always_comb begin
        s_d = s_q;
        if (!en) begin
            s_d.wptr = '0;
            s_d.fill = '0;
        end else if (wr_hit) begin
            s_d.wptr = (s_q.wptr >= size_m1) ? '0 : s_q.wptr + LEN_W'(1);
            s_d.fill = (s_q.fill >= size_full) ? size_full : s_q.fill + FILL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wptr = s_q.wptr;
    assign fill = s_q.fill;

    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (wptr == '0 && fill == '0));
    a_r2_pointer_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_hit && wptr == size_m1) |=> (wptr == '0));
    a_r4_fill_capped: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_hit) |=> (!$stable(size_m1) || fill <= ({1'b0, size_m1} + FILL_W'(1))));
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr_hit) |=> (!$stable(en) || $stable(wptr)));
endmodule

// File: rtl/ring_rd_calc.sv
// Read-side address: bounds test and modular history index.
module ring_rd_calc #(
    parameter int ADDR_W = 11,
    parameter int LEN_W  = 8
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  wptr,
    input  logic [LEN_W:0]    fill,
    input  logic [LEN_W-1:0]  size_m1,
    input  logic [LEN_W-1:0]  ofs,
    output logic [ADDR_W-1:0] addr,
    output logic              oob
);
    localparam int IW = LEN_W + 1;

    logic [IW-1:0] size_full, back, idx;

    always_comb begin
        size_full = {1'b0, size_m1} + IW'(1);
        oob       = !en || ({1'b0, ofs} >= fill);
        // wptr + size - 1 - ofs stays in [0, 2*size) whenever ofs < size
        back      = {1'b0, wptr} + size_full - IW'(1) - {1'b0, ofs};
        idx       = (back >= size_full) ? back - size_full : back;
        addr      = oob ? base : base + ADDR_W'(idx);
    end

    always_comb begin
        if (!oob) begin
            a_r3_index_inside: assert (idx <= {1'b0, size_m1} || fill > size_full);
        end
    end
endmodule

// File: rtl/ring_err_latch.sv
// Sticky out-of-bounds flag with masked interrupt.
module ring_err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);
    typedef struct packed {
        logic err;
    } err_t;

    err_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (set)      e_d.err = 1'b1;
        else if (clr) e_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign flag = e_q.err;
    assign irq  = e_q.err & ie;

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
endmodule

// File: rtl/chan_ring_addresser.sv
module chan_ring_addresser
    import ringaddr_pkg::*;
#(
    parameter int NUM_CH = RA_NUM_CH,
    parameter int ADDR_W = RA_ADDR_W,
    parameter int LEN_W  = RA_LEN_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         cfg_start,
    input  logic [ADDR_W-1:0]         cfg_pitch,
    input  logic [LEN_W-1:0]          cfg_size_m1,
    input  logic [NUM_CH-1:0]         ch_enable,
    input  logic                      wr_req,
    input  logic [$clog2(NUM_CH)-1:0] wr_ch,
    output logic [ADDR_W-1:0]         wr_addr,
    input  logic                      rd_req,
    input  logic [$clog2(NUM_CH)-1:0] rd_ch,
    input  logic [LEN_W-1:0]          rd_ofs,
    output logic [ADDR_W-1:0]         rd_addr,
    input  logic                      err_clr,
    input  logic                      err_ie,
    output logic                      err_flag,
    output logic                      irq
);
    localparam int CH_W = $clog2(NUM_CH);

    logic [LEN_W-1:0]  wptr_arr [NUM_CH];
    logic [LEN_W:0]    fill_arr [NUM_CH];
    logic [NUM_CH-1:0] wr_hit;

    logic [ADDR_W-1:0] wr_base, rd_base;
    logic [LEN_W-1:0]  wr_wptr, rd_wptr;
    logic [LEN_W:0]    rd_fill;
    logic              rd_en, rd_oob;

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
            assign wr_hit[i] = wr_req && (wr_ch == CH_W'(i));
            ring_slot #(.LEN_W(LEN_W)) slot_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (ch_enable[i]),
                .wr_hit  (wr_hit[i]),
                .size_m1 (cfg_size_m1),
                .wptr    (wptr_arr[i]),
                .fill    (fill_arr[i])
            );
        end
    endgenerate

    // channel selection; an index past the last channel selects nothing
    always_comb begin
        wr_wptr = '0;
        rd_wptr = '0;
        rd_fill = '0;
        rd_en   = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_ch == CH_W'(i)) wr_wptr = wptr_arr[i];
            if (rd_ch == CH_W'(i)) begin
                rd_wptr = wptr_arr[i];
                rd_fill = fill_arr[i];
                rd_en   = ch_enable[i];
            end
        end
        wr_base = cfg_start + ADDR_W'(wr_ch) * cfg_pitch;
        rd_base = cfg_start + ADDR_W'(rd_ch) * cfg_pitch;
        wr_addr = wr_base + ADDR_W'(wr_wptr);
    end

    ring_rd_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) rd_calc_i (
        .en      (rd_en),
        .base    (rd_base),
        .wptr    (rd_wptr),
        .fill    (rd_fill),
        .size_m1 (cfg_size_m1),
        .ofs     (rd_ofs),
        .addr    (rd_addr),
        .oob     (rd_oob)
    );

    ring_err_latch err_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (rd_req && rd_oob),
        .clr   (err_clr),
        .ie    (err_ie),
        .flag  (err_flag),
        .irq   (irq)
    );

    a_r5_bad_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ofs == '0 && !ch_enable[0] && rd_ch == '0) |=> err_flag);
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (err_flag && err_ie));
endmodule

// File: tb/chan_ring_addresser_tb_top.sv
module chan_ring_addresser_tb_top;
    localparam int NCH = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] cfg_start = '0, cfg_pitch = '0;
    logic [7:0]  cfg_size_m1 = '0;
    logic [9:0]  ch_enable = '0;
    logic        wr_req = 1'b0, rd_req = 1'b0, err_clr = 1'b0, err_ie = 1'b0;
    logic [3:0]  wr_ch = '0, rd_ch = '0;
    logic [7:0]  rd_ofs = '0;
    logic [10:0] wr_addr, rd_addr;
    logic        err_flag, irq;

    int checks = 0, fails = 0;
    int m_wp [NCH];
    int m_fill [NCH];
    bit m_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    chan_ring_addresser dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_pitch(cfg_pitch),
        .cfg_size_m1(cfg_size_m1), .ch_enable(ch_enable), .wr_req(wr_req),
        .wr_ch(wr_ch), .wr_addr(wr_addr), .rd_req(rd_req), .rd_ch(rd_ch),
        .rd_ofs(rd_ofs), .rd_addr(rd_addr), .err_clr(err_clr), .err_ie(err_ie),
        .err_flag(err_flag), .irq(irq)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int m_base(int ch);
        return (int'(cfg_start) + ch * int'(cfg_pitch)) % 2048;
    endfunction

    task automatic set_en(logic [9:0] mask);
        ch_enable = mask;
        for (int i = 0; i < NCH; i++)
            if (!mask[i]) begin m_wp[i] = 0; m_fill[i] = 0; end
        @(negedge clk);
    endtask

    // write one sample, checking the address shown for it
    task automatic do_write(int ch, string tag);
        int exp;
        wr_req = 1'b1;
        wr_ch  = 4'(ch);
        #1;
        if (ch < NCH) begin
            exp = (m_base(ch) + m_wp[ch]) % 2048;
            check(int'(wr_addr) == exp, tag, int'(wr_addr), exp);
        end
        @(negedge clk);
        wr_req = 1'b0;
        if (ch < NCH && ch_enable[ch]) begin
            m_wp[ch]   = (m_wp[ch] >= int'(cfg_size_m1)) ? 0 : m_wp[ch] + 1;
            m_fill[ch] = (m_fill[ch] >= int'(cfg_size_m1) + 1) ? int'(cfg_size_m1) + 1 : m_fill[ch] + 1;
        end
    endtask

    // read at offset k; checks address now and error flag one cycle on
    task automatic do_read(int ch, int k, bit clr, string tag);
        int exp, sz;
        bit oob;
        sz  = int'(cfg_size_m1) + 1;
        oob = (ch >= NCH) || !ch_enable[ch] || (k >= m_fill[ch]);
        rd_req = 1'b1; rd_ch = 4'(ch); rd_ofs = 8'(k); err_clr = clr;
        #1;
        if (ch < NCH) begin
            exp = oob ? m_base(ch) : (m_base(ch) + ((m_wp[ch] - 1 - k + sz) % sz)) % 2048;
            check(int'(rd_addr) == exp, tag, int'(rd_addr), exp);
        end
        @(negedge clk);
        rd_req = 1'b0; err_clr = 1'b0;
        if (oob) m_err = 1;
        else if (clr) m_err = 0;
        #1;
        check(err_flag == m_err, {tag, " flag"}, int'(err_flag), int'(m_err));
    endtask

    task automatic clear_err();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        m_err = 0;
        #1;
        check(err_flag == 1'b0, "R6 clear", int'(err_flag), 0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < NCH; i++) begin m_wp[i] = 0; m_fill[i] = 0; end
        repeat (3) @(negedge clk);
        #1;
        check(err_flag == 1'b0, "R6 reset flag", int'(err_flag), 0);
        check(irq == 1'b0, "R7 reset irq", int'(irq), 0);
        check(wr_addr == 11'd0, "R1 reset addr", int'(wr_addr), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_layout();
        cfg_start = 11'd100; cfg_pitch = 11'd40; cfg_size_m1 = 8'd7;
        set_en(10'h3FF);
        for (int c = 0; c < NCH; c++) do_write(c, "R1 layout");
    endtask

    task automatic t_wrap();
        for (int n = 0; n < 10; n++) do_write(3, "R2 ring advance");
        for (int k = 0; k < 8; k++) do_read(3, k, 1'b0, "R4 full ring read");
        do_read(3, 2, 1'b0, "R3 history offset");
        do_read(4, 0, 1'b0, "R3 neighbour untouched");
    endtask

    task automatic t_partial();
        do_read(5, 0, 1'b0, "R3 newest");
        do_read(5, 1, 1'b0, "R5 beyond fill");
        do_read(5, 0, 1'b0, "R6 flag held");
    endtask

    task automatic t_irq();
        err_ie = 1'b0; #1;
        check(irq == 1'b0, "R7 masked", int'(irq), 0);
        err_ie = 1'b1; #1;
        check(irq == 1'b1, "R7 enabled", int'(irq), 1);
        clear_err();
        check(irq == 1'b0, "R7 after clear", int'(irq), 0);
        do_read(6, 3, 1'b1, "R6 set beats clear");
        check(irq == 1'b1, "R7 raised", int'(irq), 1);
        clear_err();
        err_ie = 1'b0;
    endtask

    task automatic t_disable();
        do_write(2, "R9 prefill");
        do_write(2, "R9 prefill");
        set_en(10'h3FB);
        do_write(2, "R8 write while off");
        do_write(2, "R8 write while off");
        set_en(10'h3FF);
        do_read(2, 0, 1'b0, "R8 ignored write");
        clear_err();
        do_write(2, "R9 pointer restarted");
        do_read(2, 0, 1'b0, "R9 single sample");
        do_write(12, "R8 bad index write");
        do_read(12, 0, 1'b0, "R5 bad index read");
        clear_err();
    endtask

    task automatic t_modwrap();
        set_en(10'h000);
        cfg_start = 11'd2000; cfg_pitch = 11'd100; cfg_size_m1 = 8'd255;
        set_en(10'h3FF);
        check(m_base(9) == 852, "R10 model base", m_base(9), 852);
        for (int n = 0; n < 3; n++) do_write(9, "R10 wrapped base");
        do_read(9, 2, 1'b0, "R10 wrapped read");
        do_read(9, 2, 1'b0, "R10 no error");
    endtask

    initial begin
        t_reset();
        t_layout();
        t_wrap();
        t_partial();
        t_irq();
        t_disable();
        t_modwrap();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule